// File: doc/BRIEF.md
# Video Gain and Black-Level Loop Controller

This block closes the digital side of a video front end's gain and offset loops. It watches the 8-bit codes coming out of a video converter, together with two strobes. One strobe frames the sync tip and the other frames the back porch. When a strobe closes, the block works out the mean code inside that window and compares it against a fixed reference. It then issues at most one single-clock pump command. The sync window drives gain up or gain down on the amplifier gain capacitor. The porch window drives charge or discharge on the black-level clamp capacitor. The analog parts are outside the block and are seen only through these commands.

The block has two operating modes. It leaves reset in a coarse acquisition mode. In this mode any full-scale sample (code 255) seen during a line overrides the sync comparison with a gain reduction, so that a strong signal is pulled into range quickly. Once both strobes have arrived cleanly and separately for a run of lines, the block moves to a fine tracking mode. In fine mode the peak override is off, and gain follows the sync-tip comparison alone. If the strobes overlap, or either one disappears for a long stretch, the block falls back to coarse mode. An in-range flag reports when the last sync-tip mean and the last black mean both sit close to their targets.

Top module: `video_level_loop`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to coarse mode (`fine_mode`=0). After that edge all four pump outputs and `in_range` are 0, and the window accumulators are cleared.
- R2: When the sync window closes with mean code above SYNC_REF+DEAD_BAND (above 1 by default), and no override applies, `gain_up` pulses. The window closes at the first clock edge where `sync_gate` is sampled low after being high, and the pulse is visible in the clock cycle after that edge.
- R3: When every sample in a closing sync window is code 0 (a clipped tip), `gain_dn` pulses instead of any gain increase.
- R4: When the sync-window mean lies above 0 and at most 1, no gain pulse is issued. This is the dead band.
- R5: When the porch window closes, `clamp_chg` pulses if the mean is below 63, `clamp_dis` pulses if it is above 65, and neither pulses otherwise.
- R6: Every pump output is high for exactly one clock and at most once per gate window. Each pulse appears only in the cycle after that window closes.
- R7: In coarse mode, if any sample equal to 255 arrived after the previous sync-window close and before the current one, `gain_dn` pulses at the current close. This takes priority over R2.
- R8: In fine mode, samples at 255 have no effect, and the gain decision follows R2 to R4 only.
- R9: A line is good when its sync window closes with at least MIN_GATE (4) samples, at least one porch window of at least 4 samples closed since the previous sync close, and the two gates were never high together. `fine_mode` rises at the sync close that completes GOOD_LINES (8) consecutive good lines.
- R10: A clock edge with `sync_gate` and `porch_gate` both high forces coarse mode from the next cycle and restarts the good-line count.
- R11: If either gate fails to close for LINE_CLKS*LOSS_LINES clocks (2048 by default), the block returns to coarse mode.
- R12: `in_range` is high when the latest sync mean is at most 2 and the latest porch mean lies in 62..66. Each part is refreshed at its own window close.
- R13: A line whose sync window is shorter than 4 samples is not good. It restarts the consecutive count without leaving the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adc_code | input | 8 | Converter sample, one per clock |
| sync_gate | input | 1 | High during the sync-tip window |
| porch_gate | input | 1 | High during the back-porch window |
| gain_up | output | 1 | One-clock command to raise amplifier gain |
| gain_dn | output | 1 | One-clock command to lower amplifier gain |
| clamp_chg | output | 1 | One-clock command to charge the clamp (raise black) |
| clamp_dis | output | 1 | One-clock command to discharge the clamp (lower black) |
| fine_mode | output | 1 | 1 in fine tracking mode, 0 in coarse acquisition |
| in_range | output | 1 | Sync and black means both near their targets |

## Verification
The gain decision at a sync-window close can face the coarse peak override and the tip comparison in the same cycle. The same close edge can also promote the mode. The bench places a 255 sample in the gap before a shallow sync window, once in coarse mode and once in fine mode. It expects `gain_dn` in the first case and `gain_up` in the second. The eighth good line closes with a gain decision that must still follow coarse rules, and `fine_mode` must rise on that same edge. Sweeps of all 256 constant codes through each window, plus alternating two-code patterns at the dead-band edges, give expected pulses from the mean arithmetic of R2 to R5.

// File: rtl/vagc_pkg.sv
// Shared types for the video gain and black-level loop controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package vagc_pkg;

    // Operating mode of the loop controller
    typedef enum logic {
        MODE_COARSE = 1'b0,
        MODE_FINE   = 1'b1
    } vagc_mode_e;

endpackage

// File: rtl/vagc_gate_meter.sv
// Window meter: sums the samples taken while a gate is high and counts them.
// When the gate falls, it reports how the window mean compares with TARGET.
// The mean is never divided out: each band edge is tested as sum versus
// edge*count. Assumes the gate is high for at least one clock per window;
// the count saturates, and samples past saturation are dropped.
module vagc_gate_meter #(
    parameter int SMP_W  = 8,
    parameter int CNT_W  = 8,
    parameter int TARGET = 64,
    parameter int DEAD   = 1,
    parameter int WIN    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic [SMP_W-1:0] sample,
    output logic             done,
    output logic             above,
    output logic             below,
    output logic             floor_hit,
    output logic             in_win,
    output logic [CNT_W-1:0] len
);
    localparam int ACC_W   = SMP_W + CNT_W;
    localparam int CMP_W   = ACC_W + 2;
    localparam int HI_T    = TARGET + DEAD;
    localparam int LO_T    = TARGET - DEAD;
    localparam int WHI_T   = TARGET + WIN;
    localparam int WLO_T   = TARGET - WIN;

    logic             gate_q;
    logic [ACC_W-1:0] acc;
    logic [CNT_W-1:0] cnt;
    logic [CMP_W-1:0] acc_x;
    logic [CMP_W-1:0] cnt_x;
    logic             win_lo_ok;

    assign done  = gate_q & ~gate;
    assign len   = cnt;
    assign acc_x = CMP_W'(acc);
    assign cnt_x = CMP_W'(cnt);

    // Accumulate the samples inside the gate and clear them when the window closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            acc    <= '0;
            cnt    <= '0;
        end else begin
            gate_q <= gate;
            if (done) begin
                acc <= '0;
                cnt <= '0;
            end else if (gate && (cnt != {CNT_W{1'b1}})) begin
                acc <= acc + ACC_W'(sample);
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Upper band edges and the clipped-tip test
    always_comb begin
        above     = acc_x > (CMP_W'(HI_T) * cnt_x);
        floor_hit = (acc == '0);
        in_win    = win_lo_ok && (acc_x <= (CMP_W'(WHI_T) * cnt_x));
    end

    // Lower band edges exist only when they are above code zero
    generate
        if (LO_T > 0) begin : g_below
            assign below = acc_x < (CMP_W'(LO_T) * cnt_x);
        end else begin : g_no_below
            assign below = 1'b0;
        end
        if (WLO_T > 0) begin : g_win_lo
            assign win_lo_ok = acc_x >= (CMP_W'(WLO_T) * cnt_x);
        end else begin : g_no_win_lo
            assign win_lo_ok = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/vagc_gain_pump.sv
// Gain pump: turns the sync-window verdict into one-clock gain commands.
// It tracks whether a full-scale sample arrived during the current line,
// where a line runs from one sync close to the next. In coarse mode that
// flag overrides the tip comparison with a gain reduction. Assumes sync_done
// is a single-cycle strobe.
module vagc_gain_pump
    import vagc_pkg::*;
#(
    parameter int SMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] sample,
    input  logic             sync_done,
    input  logic             tip_above,
    input  logic             tip_floor,
    input  vagc_mode_e       mode,
    output logic             gain_up,
    output logic             gain_dn
);
    localparam logic [SMP_W-1:0] FULL_SCALE = {SMP_W{1'b1}};

    logic peak_seen;
    logic peak_now;

    assign peak_now = (sample == FULL_SCALE);

    // Decide the gain command at each sync close and track full-scale samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_up   <= 1'b0;
            gain_dn   <= 1'b0;
            peak_seen <= 1'b0;
        end else begin
            gain_up <= 1'b0;
            gain_dn <= 1'b0;
            if (sync_done) begin
                peak_seen <= peak_now;
                if ((mode == MODE_COARSE) && peak_seen) begin
                    gain_dn <= 1'b1;
                end else if (tip_floor) begin
                    gain_dn <= 1'b1;
                end else if (tip_above) begin
                    gain_up <= 1'b1;
                end
            end else if (peak_now) begin
                peak_seen <= 1'b1;
            end
        end
    end

    // R6
    gain_up_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_up |=> !gain_up);

    // R6
    gain_dn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_dn |=> !gain_dn);

endmodule

// File: rtl/vagc_mode_ctrl.sv
// Mode controller: counts consecutive good lines and promotes to fine mode.
// It drops back to coarse mode on a gate overlap or on a long absence of
// either gate. A line ends at each sync close. Assumes the done strobes
// come from window meters that watch the same gates.
module vagc_mode_ctrl
    import vagc_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int MIN_GATE   = 4,
    parameter int GOOD_LINES = 8,
    parameter int LINE_CLKS  = 32,
    parameter int LOSS_LINES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_a,
    input  logic             gate_b,
    input  logic             sync_done,
    input  logic             porch_done,
    input  logic [CNT_W-1:0] sync_len,
    input  logic [CNT_W-1:0] porch_len,
    output vagc_mode_e       mode
);
    localparam int LOSS_LIMIT = LINE_CLKS * LOSS_LINES;
    localparam int TMR_W      = $clog2(LOSS_LIMIT + 1);
    localparam int GOOD_W     = $clog2(GOOD_LINES + 1);
    localparam logic [TMR_W-1:0]  TMR_MAX  = TMR_W'(LOSS_LIMIT);
    localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(GOOD_LINES);
    localparam logic [GOOD_W-1:0] GOOD_LST = GOOD_W'(GOOD_LINES - 1);
    localparam logic [CNT_W-1:0]  LEN_MIN  = CNT_W'(MIN_GATE);

    logic [GOOD_W-1:0] good_cnt;
    logic [TMR_W-1:0]  a_tmr;
    logic [TMR_W-1:0]  b_tmr;
    logic              line_bad;
    logic              porch_good;
    logic              overlap;
    logic              lost_a;
    logic              lost_b;
    logic              line_good;

    assign overlap   = gate_a & gate_b;
    assign lost_a    = (a_tmr == TMR_MAX) & ~sync_done;
    assign lost_b    = (b_tmr == TMR_MAX) & ~porch_done;
    assign line_good = ~line_bad & porch_good & (sync_len >= LEN_MIN);

    // Count clocks since each gate last closed, saturating at the loss limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_tmr <= '0;
            b_tmr <= '0;
        end else begin
            if (sync_done)             a_tmr <= '0;
            else if (a_tmr != TMR_MAX) a_tmr <= a_tmr + 1'b1;
            if (porch_done)            b_tmr <= '0;
            else if (b_tmr != TMR_MAX) b_tmr <= b_tmr + 1'b1;
        end
    end

    // Qualify lines, count good ones and move between the two modes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MODE_COARSE;
            good_cnt   <= '0;
            line_bad   <= 1'b0;
            porch_good <= 1'b0;
        end else begin
            if (porch_done && (porch_len >= LEN_MIN)) porch_good <= 1'b1;
            if (overlap) line_bad <= 1'b1;
            if (sync_done) begin
                line_bad   <= 1'b0;
                porch_good <= 1'b0;
                if (line_good) begin
                    if (good_cnt != GOOD_MAX) good_cnt <= good_cnt + 1'b1;
                    if (good_cnt >= GOOD_LST) mode <= MODE_FINE;
                end else begin
                    good_cnt <= '0;
                end
            end
            if (overlap || lost_a || lost_b) begin
                mode     <= MODE_COARSE;
                good_cnt <= '0;
            end
        end
    end

    // R10
    overlap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_a && gate_b) |=> (mode == MODE_COARSE));

    // R9
    promote_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode == MODE_FINE) |-> $past(sync_done));

endmodule

// File: rtl/video_level_loop.sv
// Top of the video gain and black-level loop controller. It meters the
// sync-tip and back-porch windows, issues gain and clamp pump pulses, keeps
// the coarse/fine mode and reports the in-range flag. Assumes one converter
// sample per clock and gates synchronous to clk.
module video_level_loop
    import vagc_pkg::*;
#(
    parameter int SMP_W      = 8,
    parameter int CNT_W      = 8,
    parameter int SYNC_REF   = 0,
    parameter int BLACK_REF  = 64,
    parameter int DEAD_BAND  = 1,
    parameter int RANGE_WIN  = 2,
    parameter int MIN_GATE   = 4,
    parameter int GOOD_LINES = 8,
    parameter int LINE_CLKS  = 32,
    parameter int LOSS_LINES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] adc_code,
    input  logic             sync_gate,
    input  logic             porch_gate,
    output logic             gain_up,
    output logic             gain_dn,
    output logic             clamp_chg,
    output logic             clamp_dis,
    output logic             fine_mode,
    output logic             in_range
);
    logic             s_done, s_above, s_below, s_floor, s_win;
    logic             p_done, p_above, p_below, p_floor, p_win;
    logic [CNT_W-1:0] s_len, p_len;
    logic             sync_ok, black_ok;
    vagc_mode_e       mode;
    logic             unused_flags;

    assign unused_flags = s_below & p_floor;

    vagc_gate_meter #(
        .SMP_W(SMP_W), .CNT_W(CNT_W), .TARGET(SYNC_REF),
        .DEAD(DEAD_BAND), .WIN(RANGE_WIN)
    ) u_sync_meter (
        .clk(clk), .rst_n(rst_n), .gate(sync_gate), .sample(adc_code),
        .done(s_done), .above(s_above), .below(s_below),
        .floor_hit(s_floor), .in_win(s_win), .len(s_len)
    );

    vagc_gate_meter #(
        .SMP_W(SMP_W), .CNT_W(CNT_W), .TARGET(BLACK_REF),
        .DEAD(DEAD_BAND), .WIN(RANGE_WIN)
    ) u_porch_meter (
        .clk(clk), .rst_n(rst_n), .gate(porch_gate), .sample(adc_code),
        .done(p_done), .above(p_above), .below(p_below),
        .floor_hit(p_floor), .in_win(p_win), .len(p_len)
    );

    vagc_gain_pump #(.SMP_W(SMP_W)) u_gain (
        .clk(clk), .rst_n(rst_n), .sample(adc_code), .sync_done(s_done),
        .tip_above(s_above), .tip_floor(s_floor), .mode(mode),
        .gain_up(gain_up), .gain_dn(gain_dn)
    );

    vagc_mode_ctrl #(
        .CNT_W(CNT_W), .MIN_GATE(MIN_GATE), .GOOD_LINES(GOOD_LINES),
        .LINE_CLKS(LINE_CLKS), .LOSS_LINES(LOSS_LINES)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .gate_a(sync_gate), .gate_b(porch_gate),
        .sync_done(s_done), .porch_done(p_done),
        .sync_len(s_len), .porch_len(p_len), .mode(mode)
    );

    // Issue clamp pulses at porch close and refresh the in-range halves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clamp_chg <= 1'b0;
            clamp_dis <= 1'b0;
            sync_ok   <= 1'b0;
            black_ok  <= 1'b0;
        end else begin
            clamp_chg <= p_done & p_below;
            clamp_dis <= p_done & p_above;
            if (s_done) sync_ok  <= s_win;
            if (p_done) black_ok <= p_win;
        end
    end

    assign fine_mode = (mode == MODE_FINE);
    assign in_range  = sync_ok & black_ok;

    // R6
    clamp_after_porch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_chg || clamp_dis) |-> ($past(porch_gate, 2) && !$past(porch_gate)));

    // R6
    gain_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_up || gain_dn) |-> ($past(sync_gate, 2) && !$past(sync_gate)));

    // R5
    clamp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_chg |-> !clamp_dis);

endmodule

// File: tb/tb_video_level_loop.sv
module tb_video_level_loop;
    localparam int CLK_PERIOD = 10;
    localparam int FILL       = 100;
    localparam int LOSS_CLKS  = 32 * 64;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] adc_code = 8'(FILL);
    logic       sync_gate = 1'b0;
    logic       porch_gate = 1'b0;
    logic       gain_up, gain_dn, clamp_chg, clamp_dis, fine_mode, in_range;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    // Bench-side model state, derived from the requirements
    bit  b_fine = 1'b0;
    int  b_good = 0;
    bit  b_sync_ok = 1'b0;
    bit  b_black_ok = 1'b0;
    bit  b_porch_good = 1'b0;
    bit  b_peak = 1'b0;

    video_level_loop dut (
        .clk(clk), .rst_n(rst_n), .adc_code(adc_code),
        .sync_gate(sync_gate), .porch_gate(porch_gate),
        .gain_up(gain_up), .gain_dn(gain_dn),
        .clamp_chg(clamp_chg), .clamp_dis(clamp_dis),
        .fine_mode(fine_mode), .in_range(in_range)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one gate window of alternating codes, then close it; returns after the close edge
    task automatic run_gate(bit is_sync, int v0, int v1, int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (is_sync) sync_gate = 1'b1; else porch_gate = 1'b1;
            adc_code = 8'((i % 2) ? v1 : v0);
            if (((i % 2) ? v1 : v0) == 255) b_peak = 1'b1;
        end
        @(negedge clk);
        sync_gate  = 1'b0;
        porch_gate = 1'b0;
        adc_code   = 8'(FILL);
        @(negedge clk);
    endtask

    // One line: porch window, short gap, sync window; checks every output it affects
    task automatic do_line(int pv0, int pv1, int plen, int sv0, int sv1, int slen,
                           bit peak, string mtag);
        int  psum, ssum;
        bit  e_up, e_dn, good;
        string gtag;
        psum = ((plen + 1) / 2) * pv0 + (plen / 2) * pv1;
        ssum = ((slen + 1) / 2) * sv0 + (slen / 2) * sv1;
        run_gate(1'b0, pv0, pv1, plen);
        chk("R5", "clamp_chg", int'(clamp_chg), int'(psum < 63 * plen));
        chk("R5", "clamp_dis", int'(clamp_dis), int'(psum > 65 * plen));
        b_black_ok   = (psum >= 62 * plen) && (psum <= 66 * plen);
        b_porch_good = b_porch_good || (plen >= 4);
        @(negedge clk);
        chk("R6", "clamp pulse width", int'(clamp_chg | clamp_dis), 0);
        if (peak) begin
            adc_code = 8'd255;
            b_peak = 1'b1;
        end
        @(negedge clk);
        adc_code = 8'(FILL);
        run_gate(1'b1, sv0, sv1, slen);
        e_up = 1'b0;
        e_dn = 1'b0;
        if (!b_fine && b_peak) begin
            e_dn = 1'b1; gtag = "R7";
        end else if (ssum == 0) begin
            e_dn = 1'b1; gtag = "R3";
        end else if (ssum > slen) begin
            e_up = 1'b1; gtag = b_peak ? "R8" : "R2";
        end else begin
            gtag = "R4";
        end
        chk(gtag, "gain_up", int'(gain_up), int'(e_up));
        chk(gtag, "gain_dn", int'(gain_dn), int'(e_dn));
        good = b_porch_good && (slen >= 4);
        if (good) begin
            if (b_good < 8) b_good++;
            if (b_good == 8) b_fine = 1'b1;
        end else begin
            b_good = 0;
        end
        b_porch_good = 1'b0;
        b_peak = 1'b0;
        b_sync_ok = (ssum <= 2 * slen);
        chk(mtag, "fine_mode", int'(fine_mode), int'(b_fine));
        chk("R12", "in_range", int'(in_range), int'(b_sync_ok && b_black_ok));
        @(negedge clk);
        chk("R6", "gain pulse width", int'(gain_up | gain_dn), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: finished=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "gain_up", int'(gain_up), 0);
        chk("R1", "gain_dn", int'(gain_dn), 0);
        chk("R1", "clamp_chg", int'(clamp_chg), 0);
        chk("R1", "clamp_dis", int'(clamp_dis), 0);
        chk("R1", "fine_mode", int'(fine_mode), 0);
        chk("R1", "in_range", int'(in_range), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: coarse peak override beats a shallow tip
        do_line(64, 64, 5, 10, 10, 4, 1'b1, "R9");
        // R9: good lines in coarse, promotion on the eighth
        for (int k = 0; k < 7; k++) do_line(64, 64, 5, 0, 1, 4, 1'b0, "R9");
        // R8: peak ignored in fine mode
        do_line(64, 64, 5, 10, 10, 4, 1'b1, "R9");
        // R2 R4 R5: dead-band edges with alternating codes
        do_line(63, 62, 4, 1, 2, 4, 1'b0, "R9");
        do_line(65, 66, 4, 0, 3, 5, 1'b0, "R9");
        do_line(63, 66, 4, 0, 1, 4, 1'b0, "R9");
        do_line(62, 62, 6, 3, 3, 4, 1'b0, "R12");
        // Sweeps of every constant code through each window
        for (int v = 0; v < 256; v++) do_line(v, v, 4, 1, 1, 4, 1'b0, "R9");
        for (int v = 0; v < 256; v++) do_line(64, 64, 4, v, v, 4, 1'b0, "R9");

        // R10: one overlapping edge drops to coarse
        @(negedge clk);
        sync_gate = 1'b1;
        porch_gate = 1'b1;
        @(negedge clk);
        chk("R10", "fine_mode after overlap", int'(fine_mode), 0);
        sync_gate = 1'b0;
        porch_gate = 1'b0;
        repeat (3) @(negedge clk);
        b_fine = 1'b0;
        b_good = 0;
        b_porch_good = 1'b0;
        b_sync_ok = 1'b0;
        b_black_ok = 1'b0;
        b_peak = 1'b0;

        // R13: a short sync window restarts the count
        for (int k = 0; k < 5; k++) do_line(64, 64, 5, 1, 1, 4, 1'b0, "R13");
        do_line(64, 64, 5, 1, 1, 3, 1'b0, "R13");
        for (int k = 0; k < 8; k++) do_line(64, 64, 5, 1, 1, 4, 1'b0, "R13");

        // R11: gate loss returns to coarse
        repeat (LOSS_CLKS - 40) @(negedge clk);
        chk("R11", "fine_mode before loss limit", int'(fine_mode), 1);
        repeat (50) @(negedge clk);
        chk("R11", "fine_mode after loss limit", int'(fine_mode), 0);
        b_fine = 1'b0;
        b_good = 0;
        do_line(64, 64, 5, 1, 1, 4, 1'b0, "R11");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule